// File: doc/BRIEF.md
# Integer ALU with Six-Flag Status Register

This block combines add, subtract and the three bitwise operations AND, OR and XOR on operands up to 32 bits wide, with a size select that narrows the operation to 8 or 16 bits. Alongside the result it derives six status bits: carry (borrow on subtract), signed overflow, sign, zero, auxiliary carry out of the low nibble, and even parity of the low result byte. The result and the live flag set are combinational. A flags register captures the live set on any clock edge where the update enable is high, and otherwise keeps its value.

A surrounding datapath presents the opcode, size and operands, takes the result in the same cycle, and raises the update enable for operations whose outcome should be recorded. The recorded flags are available from the following cycle.

Top module: `arith_flag_unit`

## Requirements
- R1: Opcode 0 (add) gives res_o equal to (a + b) modulo 2^n, where n is the active size, and every res_o bit at position n or above is 0.
- R2: Opcode 1 (subtract) gives res_o equal to (a - b) modulo 2^n over the low n bits, and res_o bits at position n or above are 0.
- R3: Opcodes 2, 3 and 4 give bitwise AND, OR and XOR of the low n bits (upper bits 0), and for these the carry, overflow and auxiliary carry flags are 0.
- R4: Carry (flag bit 0) is the carry out of bit n-1 for add, and for subtract is 1 exactly when the low n bits of a are less than those of b as unsigned values.
- R5: Overflow (flag bit 5) is 1 when the signed two's-complement result of add or subtract, at size n, falls outside the n-bit signed range.
- R6: Sign (flag bit 4) equals res_o bit n-1.
- R7: Zero (flag bit 3) is 1 exactly when all n result bits are 0.
- R8: For add and subtract, auxiliary carry (flag bit 2) is the carry or borrow from bit 3 into bit 4, equal to bit 4 of a XOR b XOR result.
- R9: Parity (flag bit 1) is 1 when res_o bits 7..0 hold an even number of ones, at every size.
- R10: While rst_n is low flags_q_o is 0; afterwards, on a rising edge with upd_i high flags_q_o takes the flags_now_o value of that cycle, and with upd_i low it is unchanged.
- R11: Opcodes 5, 6 and 7 are reserved: res_o is 0 and flags follow the logical rules (zero and parity 1, all others 0).
- R12: Size code 0 selects 8 bits, 1 selects 16 bits, and both 2 and 3 select 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the flags register |
| op_i | input | 3 | Operation code (0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5..7 reserved) |
| size_i | input | 2 | Operand size (0: 8 bits, 1: 16 bits, 2 or 3: 32 bits) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| upd_i | input | 1 | Capture live flags into the flags register at the next rising edge |
| res_o | output | 32 | Combinational result, zero above the active size |
| flags_now_o | output | 6 | Live flags {overflow, sign, zero, aux, parity, carry} |
| flags_q_o | output | 6 | Registered flags, same bit layout |

## Verification
The two functions that share a cycle are the capture of the flags register and the evaluation of the next operation: with upd_i held high over back-to-back operations, each edge must record the flags of the operand set presented just before it while flags_now_o already reflects the new one. The bench provokes this by changing opcode, size and operands at every falling edge with the enable high, and judges flags_q_o one edge later against flags it computes itself from the requirements; a following cycle with the enable low and different operands must leave the recorded value untouched.

// File: rtl/afu_pkg.sv
package afu_pkg;

   localparam logic [2:0] OP_ADD = 3'd0;
   localparam logic [2:0] OP_SUB = 3'd1;
   localparam logic [2:0] OP_AND = 3'd2;
   localparam logic [2:0] OP_OR  = 3'd3;
   localparam logic [2:0] OP_XOR = 3'd4;

   localparam int NUM_LANES = 3;
   localparam int FLAG_W    = 6;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic cry;
   } afu_flags_t;

endpackage

// File: rtl/afu_adder.sv
module afu_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0]                    a,
   input  logic [W-1:0]                    b,
   input  logic                            sub,
   output logic [afu_pkg::NUM_LANES-1:0][W-1:0] lane_sum,
   output logic [afu_pkg::NUM_LANES-1:0]        lane_cry,
   output logic [afu_pkg::NUM_LANES-1:0]        lane_ovf
);
   import afu_pkg::*;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? W / 4 : (g == 1) ? W / 2 : W;
      logic [LW-1:0] bb;
      logic [LW:0]   s;

      assign bb = sub ? ~b[LW-1:0] : b[LW-1:0];
      assign s  = {1'b0, a[LW-1:0]} + {1'b0, bb} + {{LW{1'b0}}, sub};

      if (LW < W) begin : g_pad
         assign lane_sum[g] = {{(W-LW){1'b0}}, s[LW-1:0]};
      end else begin : g_full
         assign lane_sum[g] = s[LW-1:0];
      end

      // carry out inverted on subtract gives the borrow
      assign lane_cry[g] = s[LW] ^ sub;
      assign lane_ovf[g] = (a[LW-1] ~^ bb[LW-1]) & (s[LW-1] ^ a[LW-1]);
   end

endmodule

// File: rtl/afu_logic.sv
module afu_logic #(
   parameter int W = 32
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res
);
   import afu_pkg::*;

   always_comb begin
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/afu_flag_gen.sv
module afu_flag_gen #(
   parameter int W = 32
) (
   input  logic [W-1:0]       res,
   input  logic [W-1:0]       a,
   input  logic [W-1:0]       b,
   input  logic [1:0]         lane,
   input  logic               arith,
   input  logic               cry_in,
   input  logic               ovf_in,
   output afu_pkg::afu_flags_t flags
);
   import afu_pkg::*;

   logic [NUM_LANES-1:0] msb_bits;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_msb
      localparam int LW = (g == 0) ? W / 4 : (g == 1) ? W / 2 : W;
      assign msb_bits[g] = res[LW-1];
   end

   always_comb begin
      flags.cry = arith & cry_in;
      flags.ovf = arith & ovf_in;
      flags.aux = arith & (a[4] ^ b[4] ^ res[4]);
      flags.sgn = msb_bits[lane];
      flags.zro = ~|res;
      flags.par = ~^res[7:0];
   end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit #(
   parameter int W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           op_i,
   input  logic [1:0]           size_i,
   input  logic [W-1:0]         a_i,
   input  logic [W-1:0]         b_i,
   input  logic                 upd_i,
   output logic [W-1:0]         res_o,
   output logic [afu_pkg::FLAG_W-1:0] flags_now_o,
   output logic [afu_pkg::FLAG_W-1:0] flags_q_o
);
   import afu_pkg::*;

   if (W < 32 || (W % 4) != 0) begin : g_bad_width
      $error("arith_flag_unit: W must be a multiple of 4 and at least 32");
   end

   logic [1:0]                  lane;
   logic                        arith;
   logic [NUM_LANES-1:0][W-1:0] lane_mask;
   logic [NUM_LANES-1:0][W-1:0] lane_sum;
   logic [NUM_LANES-1:0]        lane_cry;
   logic [NUM_LANES-1:0]        lane_ovf;
   logic [W-1:0]                a_m, b_m, logic_res;
   afu_flags_t                  flags_now;
   afu_flags_t                  flags_q;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
      localparam int LW = (g == 0) ? W / 4 : (g == 1) ? W / 2 : W;
      if (LW < W) begin : g_part
         assign lane_mask[g] = {{(W-LW){1'b0}}, {LW{1'b1}}};
      end else begin : g_all
         assign lane_mask[g] = {W{1'b1}};
      end
   end

   always_comb begin
      case (size_i)
         2'd0:    lane = 2'd0;
         2'd1:    lane = 2'd1;
         default: lane = 2'd2;
      endcase
   end

   assign arith = (op_i == OP_ADD) || (op_i == OP_SUB);
   assign a_m   = a_i & lane_mask[lane];
   assign b_m   = b_i & lane_mask[lane];

   afu_adder #(.W(W)) u_add (
      .a        (a_i),
      .b        (b_i),
      .sub      (op_i == OP_SUB),
      .lane_sum (lane_sum),
      .lane_cry (lane_cry),
      .lane_ovf (lane_ovf)
   );

   afu_logic #(.W(W)) u_logic (
      .op  (op_i),
      .a   (a_m),
      .b   (b_m),
      .res (logic_res)
   );

   assign res_o = arith ? lane_sum[lane] : logic_res;

   afu_flag_gen #(.W(W)) u_flags (
      .res    (res_o),
      .a      (a_m),
      .b      (b_m),
      .lane   (lane),
      .arith  (arith),
      .cry_in (lane_cry[lane]),
      .ovf_in (lane_ovf[lane]),
      .flags  (flags_now)
   );

   assign flags_now_o = flags_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (upd_i) begin
         flags_q <= flags_now;
      end
   end

   assign flags_q_o = flags_q;

endmodule

// File: rtl/afu_chk.sv
module afu_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   op_i,
   input logic [1:0]   size_i,
   input logic         upd_i,
   input logic [W-1:0] res_o,
   input logic [5:0]   flags_now_o,
   input logic [5:0]   flags_q_o
);

   // R10: capture on enable
   assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> (flags_q_o == $past(flags_now_o)));

   // R10: hold without enable
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(flags_q_o));

   // R3: logical ops clear carry, aux and overflow
   assert_logic_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 3'd2) |-> (flags_now_o[0] == 1'b0 && flags_now_o[2] == 1'b0 && flags_now_o[5] == 1'b0));

   // R1: upper bits zero at 8-bit size
   assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'd0) |-> (res_o[W-1:W/4] == '0));

   // R6: sign follows result msb at 8 and 32 bits
   assert_sign8_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'd0) |-> (flags_now_o[4] == res_o[W/4-1]));
   assert_sign32_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i[1] == 1'b1) |-> (flags_now_o[4] == res_o[W-1]));

   // R7: zero flag against the result
   assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flags_now_o[3] == (res_o == '0));

   // R11: reserved opcodes give a zero result
   assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 3'd5) |-> (res_o == '0));

endmodule

bind arith_flag_unit afu_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_i        (op_i),
   .size_i      (size_i),
   .upd_i       (upd_i),
   .res_o       (res_o),
   .flags_now_o (flags_now_o),
   .flags_q_o   (flags_q_o)
);

// File: tb/sim_arith_flag_unit.sv
module sim_arith_flag_unit;
   localparam int W          = 32;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   op = 3'd0;
   logic [1:0]   sz = 2'd0;
   logic [W-1:0] a = '0, b = '0;
   logic         upd = 1'b0;
   logic [W-1:0] res;
   logic [5:0]   fnow, fq;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   arith_flag_unit #(.W(W)) u0 (
      .clk (clk), .rst_n (rst_n), .op_i (op), .size_i (sz),
      .a_i (a), .b_i (b), .upd_i (upd),
      .res_o (res), .flags_now_o (fnow), .flags_q_o (fq)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // returns {ovf, sgn, zro, aux, par, cry, result}
   function automatic logic [W+5:0] model(input logic [2:0] o, input logic [1:0] s,
                                          input logic [W-1:0] x, input logic [W-1:0] y);
      int n;
      logic [63:0] m, mx, my, full, r;
      logic c, v, ac, sg, z, p, ar;
      n  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
      m  = (64'd1 << n) - 64'd1;
      mx = {32'd0, x} & m;
      my = {32'd0, y} & m;
      c = 0; v = 0; ac = 0; ar = 0; full = '0;
      case (o)
         3'd0: begin
            full = mx + my; r = full & m; c = full[n]; ar = 1;
            v = (mx[n-1] == my[n-1]) && (r[n-1] != mx[n-1]);
         end
         3'd1: begin
            full = mx - my; r = full & m; c = (mx < my); ar = 1;
            v = (mx[n-1] != my[n-1]) && (r[n-1] != mx[n-1]);
         end
         3'd2: r = mx & my;
         3'd3: r = mx | my;
         3'd4: r = mx ^ my;
         default: r = '0;
      endcase
      if (ar) ac = mx[4] ^ my[4] ^ r[4];
      sg = r[n-1];
      z  = (r == '0);
      p  = ~^r[7:0];
      return {v, sg, z, ac, p, c, r[W-1:0]};
   endfunction

   // drive at falling edge, check combinational outputs 1 time unit later
   task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic u, input string rtag);
      logic [W+5:0] e;
      @(negedge clk);
      op = o; sz = s; a = x; b = y; upd = u;
      #1;
      e = model(o, s, x, y);
      chk({rtag, " result"}, res, e[W-1:0]);
      if (o == 3'd0 || o == 3'd1) begin
         chk("R4 carry", {31'd0, fnow[0]}, {31'd0, e[W]});
         chk("R5 overflow", {31'd0, fnow[5]}, {31'd0, e[W+5]});
         chk("R8 auxcarry", {31'd0, fnow[2]}, {31'd0, e[W+2]});
      end else begin
         chk("R3 cry/aux/ovf clear", {29'd0, fnow[5], fnow[2], fnow[0]}, {29'd0, e[W+5], e[W+2], e[W]});
      end
      chk("R6 sign", {31'd0, fnow[4]}, {31'd0, e[W+4]});
      chk("R7 zero", {31'd0, fnow[3]}, {31'd0, e[W+3]});
      chk("R9 parity", {31'd0, fnow[1]}, {31'd0, e[W+1]});
   endtask

   task automatic t_reset;
      op = 3'd0; sz = 2'd0; a = 32'hFF; b = 32'h1; upd = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset flags", {26'd0, fq}, 32'd0);
      @(negedge clk);
      upd = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic t_add;
      apply(3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, "R1");
      chk("R1 literal 8b wrap flags", {26'd0, fnow}, 32'h0F); // Z A P C
      apply(3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, "R1");
      chk("R5 literal 8b signed ovf", {26'd0, fnow}, 32'h34); // O S A
      apply(3'd0, 2'd0, 32'hABCD_1234, 32'h1111_0008, 1'b0, "R1");
      apply(3'd0, 2'd1, 32'h0000_7FFF, 32'h0000_0001, 1'b0, "R1");
      apply(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R1");
      apply(3'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, "R1");
      apply(3'd0, 2'd2, 32'h1234_5678, 32'h0FED_CBA9, 1'b0, "R1");
   endtask

   task automatic t_sub;
      apply(3'd1, 2'd0, 32'h0000_0000, 32'h0000_0001, 1'b0, "R2");
      chk("R4 literal borrow flags", {26'd0, fnow}, 32'h17); // S A P C
      apply(3'd1, 2'd1, 32'h0000_8000, 32'h0000_0001, 1'b0, "R2");
      apply(3'd1, 2'd2, 32'h0000_0005, 32'h0000_0005, 1'b0, "R2");
      apply(3'd1, 2'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2");
      apply(3'd1, 2'd0, 32'hFFFF_FF10, 32'h0000_0001, 1'b0, "R2");
   endtask

   task automatic t_logic;
      apply(3'd2, 2'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, "R3");
      apply(3'd3, 2'd1, 32'hFFFF_0001, 32'h0000_8000, 1'b0, "R3");
      apply(3'd4, 2'd0, 32'h1234_56AA, 32'h0000_00AA, 1'b0, "R3");
      apply(3'd4, 2'd2, 32'h8000_0001, 32'h0000_0000, 1'b0, "R3");
   endtask

   task automatic t_reserved;
      for (int k = 5; k < 8; k++) begin
         apply(k[2:0], 2'd2, 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b0, "R11");
         chk("R11 reserved flags", {26'd0, fnow}, 32'h0A); // Z P
      end
   endtask

   task automatic t_size3;
      logic [W+5:0] e;
      e = model(3'd0, 2'd2, 32'hFFFF_0000, 32'h0001_0000);
      apply(3'd0, 2'd3, 32'hFFFF_0000, 32'h0001_0000, 1'b0, "R12");
      chk("R12 size3 as 32b result", res, e[W-1:0]);
      chk("R12 size3 as 32b flags", {26'd0, fnow}, {26'd0, e[W+5:W]});
   endtask

   task automatic t_register;
      logic [W+5:0] e1, e2;
      e1 = model(3'd0, 2'd0, 32'h7F, 32'h01);
      e2 = model(3'd1, 2'd1, 32'h0, 32'h1);
      apply(3'd0, 2'd0, 32'h7F, 32'h01, 1'b1, "R1");
      @(posedge clk); #1;
      chk("R10 capture first", {26'd0, fq}, {26'd0, e1[W+5:W]});
      // back-to-back: new op while previous flags just landed
      apply(3'd1, 2'd1, 32'h0, 32'h1, 1'b1, "R2");
      chk("R10 old value before edge", {26'd0, fq}, {26'd0, e1[W+5:W]});
      @(posedge clk); #1;
      chk("R10 capture second", {26'd0, fq}, {26'd0, e2[W+5:W]});
      apply(3'd2, 2'd2, 32'h0, 32'h0, 1'b0, "R3");
      @(posedge clk); #1;
      chk("R10 hold without enable", {26'd0, fq}, {26'd0, e2[W+5:W]});
      @(posedge clk); #1;
      chk("R10 hold second cycle", {26'd0, fq}, {26'd0, e2[W+5:W]});
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_reserved();
      t_size3();
      t_register();
      repeat (2) @(posedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule